// File: doc/BRIEF.md
# Pipelined Carry-Save Unsigned Multiplier

This block multiplies two 6-bit unsigned operands and returns their 12-bit product. The work is split into five registered stages, so a new operand pair can be accepted on every clock. Each result appears a fixed number of cycles after its operands were accepted.

The first stage builds one shifted copy of the multiplicand for each multiplier bit. The next three stages reduce those six rows with 3:2 carry-save compressors. Each compressor keeps its carries as a separate vector instead of rippling them, so the row count falls 6 → 4 → 3 → 2. Only the last stage performs a carry-propagate addition, which merges the two remaining rows into the product.

A valid flag moves through the stages beside the data, and the surrounding logic uses it to tell results from empty slots. There is no stall input: whatever enters always leaves five cycles later.

Top module: `csa_mult_pipe`

## Requirements
- R1: While `rst` is high, and on every cycle after it until a valid pair has had time to emerge, `res_vld` is 0.
- R2: If `op_vld` is high at a rising edge, `res_vld` is high after the fifth rising edge, counting that edge as the first.
- R3: Whenever `res_vld` is high, `res_prod` equals the unsigned product `op_a * op_b` of the pair accepted five edges earlier, as a 12-bit value.
- R4: Pairs presented on consecutive cycles come out on consecutive cycles, in the order they were accepted, with no gaps.
- R5: The largest operands, 63 × 63, give 3969, and no bit is lost in the reduction rows.
- R6: If either operand is zero, the product is zero.
- R7: A cycle with `op_vld` low shows up as a cycle with `res_vld` low in the matching output slot, whatever the operand values were.
- R8: A synchronous reset raised while pairs are in flight discards them: none of them later raises `res_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears every stage valid bit |
| op_vld | input | 1 | Marks `op_a`/`op_b` as a pair to multiply |
| op_a | input | 6 | Multiplicand, unsigned |
| op_b | input | 6 | Multiplier, unsigned |
| res_vld | output | 1 | Marks `res_prod` as a product |
| res_prod | output | 12 | Unsigned product |

## Verification
The bench covers all 4096 operand pairs back to back. That run catches a carry vector that was not shifted or was dropped, which shows up as wrong products for some operand patterns, and a latency that is one stage short or long, which shifts every result into the wrong slot. The all-ones pair and the zero-operand pairs are called out on their own, because a carry lost off the top of a 12-bit row damages only the biggest products. A second sweep puts gaps between pairs while the operand pins carry garbage, so a valid flag that ignores the input or drifts away from its data is exposed. A reset raised in the middle of a stream checks that a stage whose valid bit was left uncleared cannot let a stale product leak out.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;
    localparam int OP_W   = 6;
    localparam int PROD_W = 2 * OP_W;
    localparam int N_ROWS = OP_W;
    localparam int LAT    = 5;
    localparam logic [PROD_W-1:0] MAX_PROD = PROD_W'((2**OP_W - 1) * (2**OP_W - 1));

    typedef logic [PROD_W-1:0] row_t;
    typedef logic [N_ROWS-1:0][PROD_W-1:0] pp_rows_t;

    typedef struct packed {
        logic     vld;
        pp_rows_t rows;
    } st6_t;

    typedef struct packed {
        logic            vld;
        logic [3:0][PROD_W-1:0] rows;
    } st4_t;

    typedef struct packed {
        logic            vld;
        logic [2:0][PROD_W-1:0] rows;
    } st3_t;

    typedef struct packed {
        logic            vld;
        logic [1:0][PROD_W-1:0] rows;
    } st2_t;

    typedef struct packed {
        logic vld;
        row_t prod;
    } st_out_t;

    function automatic row_t add_rows3(row_t x, row_t y, row_t z);
        return row_t'(x + y + z);
    endfunction
endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
    parameter int OP_W   = 6,
    parameter int PROD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]                mcand,
    input  logic [OP_W-1:0]                mplier,
    output logic [OP_W-1:0][PROD_W-1:0]    rows
);
    localparam int PAD_W = PROD_W - OP_W;

    for (genvar i = 0; i < OP_W; i++) begin : g_row
        logic [PROD_W-1:0] ext;
        assign ext     = {{PAD_W{1'b0}}, mcand};
        assign rows[i] = mplier[i] ? (ext << i) : '0;
    end
endmodule

// File: rtl/csa_compress32.sv
module csa_compress32 #(
    parameter int W = 12
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    logic [W-1:0] maj;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = in_x[i] ^ in_y[i] ^ in_z[i];
        assign maj[i]   = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
    end

    assign cry_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/csa_ripple_add.sv
module csa_ripple_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    output logic [W-1:0] total
);
    logic [W:0] c;

    assign c[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign total[i] = in_x[i] ^ in_y[i] ^ c[i];
        assign c[i+1]   = (in_x[i] & in_y[i]) | (c[i] & (in_x[i] ^ in_y[i]));
    end
endmodule

// File: rtl/csa_mult_pipe.sv
module csa_mult_pipe
    import csa_mult_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_vld,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              res_vld,
    output logic [PROD_W-1:0] res_prod
);
    st6_t    s1_q;
    st4_t    s2_q;
    st3_t    s3_q;
    st2_t    s4_q;
    st_out_t s5_q;

    // Stage 1: shifted multiplicand rows
    pp_rows_t pp_d;
    csa_pp_gen #(.OP_W(OP_W), .PROD_W(PROD_W)) u_ppgen (
        .mcand (op_a),
        .mplier(op_b),
        .rows  (pp_d)
    );

    always_ff @(posedge clk) begin
        s1_q.rows <= pp_d;
        if (rst) s1_q.vld <= 1'b0;
        else     s1_q.vld <= op_vld;
    end

    // Stage 2: two compressors side by side, 6 rows -> 4
    row_t s2_sum_lo, s2_cry_lo, s2_sum_hi, s2_cry_hi;
    csa_compress32 #(.W(PROD_W)) u_csa2_lo (
        .in_x(s1_q.rows[0]), .in_y(s1_q.rows[1]), .in_z(s1_q.rows[2]),
        .sum_o(s2_sum_lo), .cry_o(s2_cry_lo)
    );
    csa_compress32 #(.W(PROD_W)) u_csa2_hi (
        .in_x(s1_q.rows[3]), .in_y(s1_q.rows[4]), .in_z(s1_q.rows[5]),
        .sum_o(s2_sum_hi), .cry_o(s2_cry_hi)
    );

    always_ff @(posedge clk) begin
        s2_q.rows <= {s2_cry_hi, s2_sum_hi, s2_cry_lo, s2_sum_lo};
        if (rst) s2_q.vld <= 1'b0;
        else     s2_q.vld <= s1_q.vld;
    end

    // Stage 3: one compressor, 4 rows -> 3 (fourth row passes through)
    row_t s3_sum, s3_cry;
    csa_compress32 #(.W(PROD_W)) u_csa3 (
        .in_x(s2_q.rows[0]), .in_y(s2_q.rows[1]), .in_z(s2_q.rows[2]),
        .sum_o(s3_sum), .cry_o(s3_cry)
    );

    always_ff @(posedge clk) begin
        s3_q.rows <= {s2_q.rows[3], s3_cry, s3_sum};
        if (rst) s3_q.vld <= 1'b0;
        else     s3_q.vld <= s2_q.vld;
    end

    // Stage 4: one compressor, 3 rows -> 2
    row_t s4_sum, s4_cry;
    csa_compress32 #(.W(PROD_W)) u_csa4 (
        .in_x(s3_q.rows[0]), .in_y(s3_q.rows[1]), .in_z(s3_q.rows[2]),
        .sum_o(s4_sum), .cry_o(s4_cry)
    );

    always_ff @(posedge clk) begin
        s4_q.rows <= {s4_cry, s4_sum};
        if (rst) s4_q.vld <= 1'b0;
        else     s4_q.vld <= s3_q.vld;
    end

    // Stage 5: the single carry-propagate add
    row_t s5_total;
    csa_ripple_add #(.W(PROD_W)) u_cpa (
        .in_x (s4_q.rows[0]),
        .in_y (s4_q.rows[1]),
        .total(s5_total)
    );

    always_ff @(posedge clk) begin
        s5_q.prod <= s5_total;
        if (rst) s5_q.vld <= 1'b0;
        else     s5_q.vld <= s4_q.vld;
    end

    assign res_vld  = s5_q.vld;
    assign res_prod = s5_q.prod;

    // Checks
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> !res_vld);

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'(LAT)) |-> (res_vld == $past(op_vld, 5)));

    assert_stage1_rows_R3: assert property (@(posedge clk) disable iff (rst)
        s1_q.vld |-> (row_t'(s1_q.rows[0] + s1_q.rows[1] + s1_q.rows[2] +
                              s1_q.rows[3] + s1_q.rows[4] + s1_q.rows[5])
                      == row_t'($past(op_a) * $past(op_b))));

    assert_stage3_keeps_sum_R3: assert property (@(posedge clk) disable iff (rst)
        s3_q.vld |-> (add_rows3(s3_q.rows[0], s3_q.rows[1], s3_q.rows[2])
                      == row_t'($past(s2_q.rows[0]) + $past(s2_q.rows[1]) +
                                $past(s2_q.rows[2]) + $past(s2_q.rows[3]))));

    assert_stage4_keeps_sum_R3: assert property (@(posedge clk) disable iff (rst)
        s4_q.vld |-> (row_t'(s4_q.rows[0] + s4_q.rows[1]) ==
                      $past(add_rows3(s3_q.rows[0], s3_q.rows[1], s3_q.rows[2]))));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_prod <= MAX_PROD));
endmodule

// File: tb/csa_mult_pipe_bench.sv
module csa_mult_pipe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 6;
    localparam int PW  = 12;
    localparam int DEPTH = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_vld = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          res_vld;
    logic [PW-1:0] res_prod;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string tag   = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    csa_mult_pipe u_csa_mult_pipe (
        .clk(clk), .rst(rst), .op_vld(op_vld),
        .op_a(op_a), .op_b(op_b),
        .res_vld(res_vld), .res_prod(res_prod)
    );

    // independent expectation line, one slot per accepted edge
    logic          ev [DEPTH];
    logic [PW-1:0] ep [DEPTH];
    logic [W-1:0]  ea [DEPTH];
    logic [W-1:0]  eb [DEPTH];

    initial for (int i = 0; i < DEPTH; i++) begin
        ev[i] = 1'b0; ep[i] = '0; ea[i] = '0; eb[i] = '0;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        for (int i = DEPTH-1; i > 0; i--) begin
            ev[i] <= rst ? 1'b0 : ev[i-1];
            ep[i] <= ep[i-1]; ea[i] <= ea[i-1]; eb[i] <= eb[i-1];
        end
        ev[0] <= rst ? 1'b0 : op_vld;
        ep[0] <= PW'(int'(op_a) * int'(op_b));
        ea[0] <= op_a; eb[0] <= op_b;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        n_checks++;
        if (res_vld !== ev[DEPTH-1]) begin
            n_fail++;
            $display("FAIL %s (R2/R7 valid slot) t=%0t: res_vld=%b expected %b",
                     tag, $time, res_vld, ev[DEPTH-1]);
        end else if (ev[DEPTH-1]) begin
            n_checks++;
            if (res_prod !== ep[DEPTH-1]) begin
                n_fail++;
                $display("FAIL %s (R3 product %0d*%0d): got %0d expected %0d",
                         tag, ea[DEPTH-1], eb[DEPTH-1], res_prod, ep[DEPTH-1]);
            end
        end
    end

    task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_vld = v; op_a = a; op_b = b;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, W'(k * 37), W'(k * 11 + 5));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run hung, cycles=%0d expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset held, outputs idle
        tag = "R1";
        repeat (6) @(negedge clk);
        drive(1'b1, 6'd63, 6'd63);  // still in reset: must be dropped (R1)
        @(negedge clk); rst = 1'b0; op_vld = 1'b0;
        idle(8);

        // R5: all-ones boundary
        tag = "R5";
        drive(1'b1, 6'd63, 6'd63);
        idle(6);

        // R6: zero operands
        tag = "R6";
        drive(1'b1, 6'd0, 6'd63);
        drive(1'b1, 6'd63, 6'd0);
        drive(1'b1, 6'd0, 6'd0);
        idle(6);

        // R3/R4: exhaustive back-to-back sweep
        tag = "R4";
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++)
                drive(1'b1, W'(a), W'(b));
        idle(6);

        // R7: bubbles with garbage operands between pairs
        tag = "R7";
        for (int k = 0; k < 200; k++) begin
            drive(1'b1, W'(k * 5 + 1), W'(63 - k));
            if (k % 3 == 0) idle(1 + (k % 2));
        end
        idle(6);

        // R8: reset in the middle of a stream
        tag = "R8";
        for (int k = 0; k < 4; k++) drive(1'b1, W'(40 + k), W'(50 + k));
        @(negedge clk); rst = 1'b1; op_vld = 1'b0;
        @(negedge clk); rst = 1'b0;
        idle(8);

        // R2: isolated single pair
        tag = "R2";
        drive(1'b1, 6'd37, 6'd45);
        idle(8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule